// File: doc/BRIEF.md
# Glitch-Free Clock Source Switch Controller

This block picks one of four source clocks as the system clock. Software can ask for a different source at any time. Software loads a 2-bit source code and pulses a set strobe. The controller then raises the switch-enable bit and powers up the chosen source. Before it hands the clock over, it counts a fixed number of start-up edges on the new source. If the new source runs through the PLL, it also waits for the lock flag. It then counts ten more synchronization edges of the new source and moves the output to it. The enable bit clears in the same cycle as the handover. If the source never toggles, the request stays pending with no time limit. Software can abort the request with a clear strobe, and a sleep request aborts it too. In both cases the old clock stays selected.

All control logic runs on a free-running reference clock `clk`. Each source arrives as a level that the block synchronizes. The output clock is rebuilt from the synchronized level of the selected source. It is turned off only during a low phase of the old source and turned back on only during a low phase of the new one, so no high pulse is ever cut short. A postscaler can divide the output by 1, 4, 16 or 64. A new ratio is taken only at a divider boundary. All pins are plain control and status lines. There is no data stream, so there is no valid/ready handshake.

Top module: `clksw_ctrl`

## Requirements
- R1: A `sw_set` pulse while `swen`=0 and `sleep_req`=0 captures `sw_nosc`. On the next cycle `swen` reads 1 and the target's bit in `src_en` is set. A `sw_set` while a switch is pending is ignored.
- R2: For a target other than the current source, `cosc` changes only after OST_EDGES (default 8) start-up rising edges of the target plus SYNC_EDGES (10) synchronization rising edges.
- R3: If the target source never toggles, `swen` stays 1 and `cosc` stays unchanged with no time limit.
- R4: When the target is source PLL_SRC (default 3), the handover waits until `pll_lock`=1. `pll_en` is 1 whenever PLL_SRC is the current source or the pending target.
- R5: `lock_sts` reads 0 one cycle after any cycle in which `pll_lock` is 0 or the PLL is not enabled.
- R6: A `sw_clr` pulse while `swen`=1 clears `swen` on the next cycle and keeps `cosc`. It also drops power to the target and the PLL enable, and it resets the edge counters, so a later request starts its count again from zero.
- R7: On completion, `cosc` takes the new value in the same cycle that `swen` falls. `cosc` never changes at any other time.
- R8: `sleep_req`=1 while `swen`=1 aborts the switch with the same effect as R6. While `sleep_req`=1, `sw_set` is ignored.
- R9: A request whose target equals `cosc` skips the start-up count. It completes after the 10 synchronization edges and leaves `clk_out` undisturbed.
- R10: With a 1:1 ratio, every high and low phase of `clk_out` lasts at least as long as the shortest phase of the two sources involved. The old source drives `clk_out` until the handover.
- R11: `post_sel` encodes 00=1:1, 01=1:4, 10=1:16, 11=1:64. A new ratio is taken only when the divider count is zero and the gated clock is low.
- R12: The `src_en` bit of the current source is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all control logic |
| rst_n | input | 1 | Active-low synchronous reset |
| src_clk | input | NSRC | Source clock levels |
| pll_lock | input | 1 | PLL lock flag |
| sw_set | input | 1 | Pulse: start a switch to `sw_nosc` |
| sw_nosc | input | SELW | Requested source code |
| sw_clr | input | 1 | Pulse: clear the enable bit and abort |
| sleep_req | input | 1 | Sleep entry request |
| post_sel | input | 2 | Postscaler ratio code |
| swen | output | 1 | Switch-enable bit (pending switch) |
| cosc | output | SELW | Current source code |
| src_en | output | NSRC | Power enables of the sources |
| pll_en | output | 1 | PLL enable |
| lock_sts | output | 1 | Lock status |
| clk_out | output | 1 | Gated, post-scaled system clock |

## Verification
The sources run with different half periods, so handovers happen at many phase alignments. A reference model compares every output on every cycle. Switching to a slow source tells the start-up count apart from the synchronization count by elapsed time. A PLL target held unlocked, and then a dead source, both show that a request can stay pending forever, and a clear or sleep abort then shows that the old clock is kept. A request to the current source and a walk through all four postscaler codes show that the output is not disturbed and that a ratio takes effect only at a divider boundary.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [2:0] {
    CS_IDLE,
    CS_WARM,
    CS_LOCK,
    CS_SYNC,
    CS_HAND
  } cs_state_t;
endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_clk,
  output logic [NSRC-1:0] lvl,
  output logic [NSRC-1:0] rise
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic m1, m2, m3;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        m1 <= 1'b0;
        m2 <= 1'b0;
        m3 <= 1'b0;
      end else begin
        m1 <= src_clk[g];
        m2 <= m1;
        m3 <= m2;
      end
    end
    assign lvl[g]  = m2;
    assign rise[g] = m2 & ~m3;
  end
endmodule

// File: rtl/clksw_fsm.sv
module clksw_fsm
  import clksw_pkg::*;
#(
  parameter int NSRC       = 4,
  parameter int SELW       = 2,
  parameter int OST_EDGES  = 8,
  parameter int SYNC_EDGES = 10,
  parameter int PLL_SRC    = 3,
  parameter int RST_SRC    = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl,
  input  logic [NSRC-1:0] rise,
  input  logic            sw_set,
  input  logic [SELW-1:0] sw_nosc,
  input  logic            sw_clr,
  input  logic            sleep_req,
  input  logic            pll_lock,
  output logic            swen,
  output logic [SELW-1:0] cosc,
  output logic            gate_on,
  output logic [NSRC-1:0] src_en,
  output logic            pll_en,
  output logic            lock_sts
);
  localparam int MAXE = (OST_EDGES > SYNC_EDGES) ? OST_EDGES : SYNC_EDGES;
  localparam int CW   = $clog2(MAXE + 1);
  localparam logic [SELW-1:0] PLL_CODE = SELW'(PLL_SRC);

  cs_state_t       st;
  logic [SELW-1:0] tgt;
  logic [CW-1:0]   cnt;
  logic            abort;

  assign abort  = swen & (sw_clr | sleep_req);
  assign src_en = (NSRC'(1) << cosc) | (swen ? (NSRC'(1) << tgt) : '0);
  assign pll_en = src_en[PLL_SRC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= CS_IDLE;
      swen     <= 1'b0;
      cosc     <= SELW'(RST_SRC);
      tgt      <= SELW'(RST_SRC);
      cnt      <= '0;
      gate_on  <= 1'b1;
      lock_sts <= 1'b0;
    end else begin
      lock_sts <= pll_en & pll_lock;
      // re-open the gate in a low phase of the (new) current source
      if (!gate_on && !lvl[cosc]) gate_on <= 1'b1;
      if (abort) begin
        st   <= CS_IDLE;
        swen <= 1'b0;
        cnt  <= '0;
      end else begin
        unique case (st)
          CS_IDLE: if (sw_set && !sleep_req) begin
            tgt  <= sw_nosc;
            swen <= 1'b1;
            cnt  <= '0;
            st   <= (sw_nosc == cosc) ? CS_SYNC : CS_WARM;
          end
          CS_WARM: if (rise[tgt]) begin
            if (cnt == CW'(OST_EDGES - 1)) begin
              cnt <= '0;
              st  <= (tgt == PLL_CODE) ? CS_LOCK : CS_SYNC;
            end else cnt <= cnt + 1'b1;
          end
          CS_LOCK: if (pll_lock) st <= CS_SYNC;
          CS_SYNC: if (rise[tgt]) begin
            if (cnt == CW'(SYNC_EDGES - 1)) begin
              cnt <= '0;
              st  <= CS_HAND;
            end else cnt <= cnt + 1'b1;
          end
          CS_HAND: begin
            if (tgt == cosc) begin
              swen <= 1'b0;
              st   <= CS_IDLE;
            end else if (!lvl[cosc]) begin
              gate_on <= 1'b0;
              cosc    <= tgt;
              swen    <= 1'b0;
              st      <= CS_IDLE;
            end
          end
          default: st <= CS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/clksw_postdiv.sv
module clksw_postdiv #(
  parameter int NSRC = 4,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl,
  input  logic [SELW-1:0] cosc,
  input  logic            gate_on,
  input  logic [1:0]      post_sel,
  output logic            clk_out
);
  localparam int PCW = 6;

  logic           gclk, gclk_d;
  logic [PCW-1:0] pcnt;
  logic [1:0]     ratio_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gclk    <= 1'b0;
      gclk_d  <= 1'b0;
      pcnt    <= '0;
      ratio_q <= 2'd0;
    end else begin
      gclk   <= gate_on & lvl[cosc];
      gclk_d <= gclk;
      if (gclk && !gclk_d) pcnt <= pcnt + 1'b1;
      if (pcnt == '0 && !gclk) ratio_q <= post_sel;
    end
  end

  always_comb begin
    unique case (ratio_q)
      2'd0:    clk_out = gclk;
      2'd1:    clk_out = pcnt[1];
      2'd2:    clk_out = pcnt[3];
      default: clk_out = pcnt[5];
    endcase
  end
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl #(
  parameter int NSRC       = 4,
  parameter int OST_EDGES  = 8,
  parameter int SYNC_EDGES = 10,
  parameter int PLL_SRC    = 3,
  parameter int RST_SRC    = 0,
  localparam int SELW      = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_clk,
  input  logic            pll_lock,
  input  logic            sw_set,
  input  logic [SELW-1:0] sw_nosc,
  input  logic            sw_clr,
  input  logic            sleep_req,
  input  logic [1:0]      post_sel,
  output logic            swen,
  output logic [SELW-1:0] cosc,
  output logic [NSRC-1:0] src_en,
  output logic            pll_en,
  output logic            lock_sts,
  output logic            clk_out
);
  logic [NSRC-1:0] lvl, rise;
  logic            gate_on;

  clksw_sync #(.NSRC(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .lvl(lvl), .rise(rise)
  );

  clksw_fsm #(
    .NSRC(NSRC), .SELW(SELW), .OST_EDGES(OST_EDGES), .SYNC_EDGES(SYNC_EDGES),
    .PLL_SRC(PLL_SRC), .RST_SRC(RST_SRC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise),
    .sw_set(sw_set), .sw_nosc(sw_nosc), .sw_clr(sw_clr),
    .sleep_req(sleep_req), .pll_lock(pll_lock),
    .swen(swen), .cosc(cosc), .gate_on(gate_on), .src_en(src_en),
    .pll_en(pll_en), .lock_sts(lock_sts)
  );

  clksw_postdiv #(.NSRC(NSRC), .SELW(SELW)) u_post (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .cosc(cosc), .gate_on(gate_on),
    .post_sel(post_sel), .clk_out(clk_out)
  );
endmodule

// File: rtl/clksw_ctrl_chk.sv
module clksw_ctrl_chk #(
  parameter int NSRC    = 4,
  parameter int SELW    = 2,
  parameter int PLL_SRC = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pll_lock,
  input logic            sw_clr,
  input logic            sleep_req,
  input logic            swen,
  input logic [SELW-1:0] cosc,
  input logic [NSRC-1:0] src_en,
  input logic            pll_en,
  input logic            lock_sts
);
  // R6: clear strobe aborts and keeps the current source
  a_r6_clear_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (swen && sw_clr) |=> (!swen && $stable(cosc)));
  // R8: sleep aborts a pending switch
  a_r8_sleep_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (swen && sleep_req) |=> (!swen && $stable(cosc)));
  // R8: no switch starts while sleep is requested
  a_r8_no_start_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (!swen && sleep_req) |=> !swen);
  // R7: the current source moves only as the enable bit falls
  a_r7_cosc_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cosc != $past(cosc)) |-> (!swen && $past(swen)));
  // R12: the running source is always powered
  a_r12_current_powered: assert property (@(posedge clk) disable iff (!rst_n)
    (cosc == SELW'(PLL_SRC) || cosc != SELW'(PLL_SRC)) |-> src_en[cosc]);
  // R4: PLL runs while it feeds the output
  a_r4_pll_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cosc == SELW'(PLL_SRC)) |-> pll_en);
  // R5: lock status drops after the lock flag is low
  a_r5_lock_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pll_lock) |-> !lock_sts);
endmodule

bind clksw_ctrl clksw_ctrl_chk #(.NSRC(NSRC), .SELW(SELW), .PLL_SRC(PLL_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .sw_clr(sw_clr),
  .sleep_req(sleep_req), .swen(swen), .cosc(cosc), .src_en(src_en),
  .pll_en(pll_en), .lock_sts(lock_sts)
);

// File: tb/sim_clksw_ctrl.sv
`timescale 1ns/1ps
module sim_clksw_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_clk = 4'b0;
  logic       pll_lock = 1'b0, sw_set = 1'b0, sw_clr = 1'b0, sleep_req = 1'b0;
  logic [1:0] sw_nosc = 2'd0, post_sel = 2'd0;
  logic       swen, pll_en, lock_sts, clk_out;
  logic [1:0] cosc;
  logic [3:0] src_en;

  int checks = 0, fails = 0, printed = 0;
  logic [3:0] dead = 4'b0;
  int half [4] = '{4, 3, 5, 2};
  int hc [4] = '{0, 0, 0, 0};

  always #2.5 clk = ~clk;

  clksw_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .pll_lock(pll_lock),
    .sw_set(sw_set), .sw_nosc(sw_nosc), .sw_clr(sw_clr), .sleep_req(sleep_req),
    .post_sel(post_sel), .swen(swen), .cosc(cosc), .src_en(src_en),
    .pll_en(pll_en), .lock_sts(lock_sts), .clk_out(clk_out)
  );

  // source generators
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (dead[i]) src_clk[i] <= 1'b0;
      else if (hc[i] == half[i] - 1) begin
        hc[i] <= 0;
        src_clk[i] <= ~src_clk[i];
      end else hc[i] <= hc[i] + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      if (printed < 30) $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      printed++;
    end
  endtask

  // behavioural reference model
  bit ms1 [4], ms2 [4], ms3 [4];
  int mph, mswen, mcosc, mtgt, mcnt, mgate, mlock, mgclk, mgd, mpcnt, mratio;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin ms1[i] = 0; ms2[i] = 0; ms3[i] = 0; end
      mph = 0; mswen = 0; mcosc = 0; mtgt = 0; mcnt = 0; mgate = 1;
      mlock = 0; mgclk = 0; mgd = 0; mpcnt = 0; mratio = 0;
    end else begin
      int nph, nswen, ncosc, ntgt, ncnt, ngate;
      bit lv, ab;
      nph = mph; nswen = mswen; ncosc = mcosc; ntgt = mtgt; ncnt = mcnt; ngate = mgate;
      lv = ms2[mcosc];
      ab = mswen && (sw_clr || sleep_req);
      if (!mgate && !lv) ngate = 1;
      if (ab) begin nph = 0; nswen = 0; ncnt = 0; end
      else if (mph == 0) begin
        if (sw_set && !sleep_req) begin
          ntgt = sw_nosc; nswen = 1; ncnt = 0;
          nph = (sw_nosc == mcosc) ? 3 : 1;
        end
      end else if (mph == 1 || mph == 3) begin
        if (ms2[mtgt] && !ms3[mtgt]) begin
          if (mcnt + 1 == ((mph == 1) ? 8 : 10)) begin
            ncnt = 0;
            nph = (mph == 3) ? 4 : ((mtgt == 3) ? 2 : 3);
          end else ncnt = mcnt + 1;
        end
      end else if (mph == 2) begin
        if (pll_lock) nph = 3;
      end else begin
        if (mtgt == mcosc) begin nswen = 0; nph = 0; end
        else if (!lv) begin ngate = 0; ncosc = mtgt; nswen = 0; nph = 0; end
      end
      mlock = ((mcosc == 3) || (mswen && mtgt == 3)) && pll_lock;
      if (mgclk && !mgd) mpcnt = (mpcnt + 1) % 64;
      if (mpcnt == 0 && !mgclk) mratio = post_sel;
      mgd = mgclk;
      mgclk = mgate && lv;
      mph = nph; mswen = nswen; mcosc = ncosc; mtgt = ntgt; mcnt = ncnt; mgate = ngate;
      for (int i = 0; i < 4; i++) begin ms3[i] = ms2[i]; ms2[i] = ms1[i]; ms1[i] = src_clk[i]; end
    end
  end

  // per-cycle comparison and phase-length tracking
  bit track_phase = 0;
  int run_len = 0, min_run = 1000;
  logic last_out = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      int exp_out, exp_en;
      exp_out = (mratio == 0) ? mgclk : ((mpcnt >> (2 * mratio - 1)) & 1);
      exp_en = (1 << mcosc) | (mswen ? (1 << mtgt) : 0);
      chk("R1 swen", swen, mswen);
      chk("R7 cosc", cosc, mcosc);
      chk("R12 src_en", src_en, exp_en);
      chk("R4 pll_en", pll_en, (exp_en >> 3) & 1);
      chk("R5 lock_sts", lock_sts, mlock);
      chk("R10 clk_out", clk_out, exp_out);
      if (track_phase) begin
        if (clk_out == last_out) run_len++;
        else begin
          if (run_len > 0 && run_len < min_run) min_run = run_len;
          run_len = 1;
        end
      end
      last_out = clk_out;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic req(input int code);
    @(negedge clk); sw_nosc = 2'(code); sw_set = 1'b1;
    @(negedge clk); sw_set = 1'b0;
  endtask

  task automatic wait_done(input int lim, output int el, output int prevc);
    el = 0; prevc = cosc;
    while (swen && el < lim) begin
      prevc = cosc;
      @(negedge clk); el++;
    end
  endtask

  int el, pc, rises;
  initial begin
    cyc(3);
    // reset state
    chk("R12 reset swen", swen, 0);
    chk("R12 reset cosc", cosc, 0);
    chk("R12 reset src_en", src_en, 1);
    chk("R10 reset clk_out", clk_out, 0);
    rst_n = 1'b1;
    cyc(20);
    track_phase = 1;
    // R1/R2/R7: switch 0 -> 2
    req(2);
    chk("R1 swen set", swen, 1);
    chk("R1 target powered", src_en, 4'b0101);
    cyc(3); req(1);  // ignored while pending (R1)
    wait_done(2000, el, pc);
    chk("R2 long enough", (el >= 165) ? 1 : 0, 1);
    chk("R7 cosc at done", cosc, 2);
    chk("R7 cosc before", pc, 0);
    cyc(30);
    // R4: PLL target held by lock
    req(3);
    cyc(300);
    chk("R4 held unlocked", swen, 1);
    chk("R4 pll enabled", pll_en, 1);
    chk("R5 status low", lock_sts, 0);
    // R6: abort
    @(negedge clk); sw_clr = 1'b1; @(negedge clk); sw_clr = 1'b0;
    chk("R6 swen cleared", swen, 0);
    chk("R6 cosc kept", cosc, 2);
    chk("R6 pll stopped", pll_en, 0);
    chk("R6 target unpowered", src_en, 4'b0100);
    // lock first, then request: full count again
    pll_lock = 1'b1;
    req(3);
    wait_done(2000, el, pc);
    chk("R6 full recount", (el >= 60) ? 1 : 0, 1);
    chk("R4 switched to pll", cosc, 3);
    cyc(2);
    chk("R5 status high", lock_sts, 1);
    pll_lock = 1'b0; cyc(2);
    chk("R5 lost lock", lock_sts, 0);
    pll_lock = 1'b1; cyc(10);
    // R3: dead source
    dead[1] = 1'b1;
    req(1);
    cyc(400);
    chk("R3 pending forever", swen, 1);
    chk("R3 cosc unchanged", cosc, 3);
    @(negedge clk); sw_clr = 1'b1; @(negedge clk); sw_clr = 1'b0;
    chk("R6 dead abort", swen, 0);
    dead[1] = 1'b0; cyc(10);
    // R8: sleep abort, and set ignored during sleep
    req(0); cyc(5);
    @(negedge clk); sleep_req = 1'b1; @(negedge clk);
    chk("R8 sleep aborts", swen, 0);
    chk("R8 old clock kept", cosc, 3);
    req(0);
    chk("R8 set ignored asleep", swen, 0);
    sleep_req = 1'b0; cyc(10);
    // R9: same source
    req(3);
    wait_done(2000, el, pc);
    chk("R9 same-source fast", (el <= 50) ? 1 : 0, 1);
    chk("R9 cosc same", cosc, 3);
    cyc(10);
    // switch 3 -> 0 for R10 and postscaler
    req(0);
    wait_done(2000, el, pc);
    chk("R10 at src0", cosc, 0);
    cyc(20);
    track_phase = 0;
    chk("R10 min phase", (min_run >= 2) ? 1 : 0, 1);
    // R11: postscaler
    post_sel = 2'd1; cyc(700);
    rises = 0;
    for (int k = 0; k < 640; k++) begin
      logic p;
      p = clk_out; @(negedge clk);
      if (clk_out && !p) rises++;
    end
    chk("R11 ratio 1:4", (rises >= 19 && rises <= 21) ? 1 : 0, 1);
    post_sel = 2'd2; cyc(1200);
    post_sel = 2'd3; cyc(1200);
    post_sel = 2'd0; cyc(1200);
    chk("R11 back to 1:1 swen", swen, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule